// File: doc/BRIEF.md
# Configuration Power-On Sequencer

This block governs power-up and restart of a configuration data source that loads a programmable logic device. Once the supply flag reports a valid supply, it holds the data source in reset for a power-on interval. Its length, short or long, is picked by a select pin. When the interval ends, the block releases its output-enable line. In the first cycle of the release it looks at the target's done line, which tells it whether to stream configuration data or to lock into idle.

While it streams, the block watches two things. One is the target's active-low status line, which signals that the target wants a new configuration. The other is a single-cycle pulse that marks the end of the data. If done has not risen by the end of the data, the block counts that as a failed load and starts over. A supply loss sends everything back to the off state, and that is the only exit from the idle lock.

Top module: `cfg_power_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, or `supply_ok` is low, `oe_drive`, `stream_en` and `idle_locked` are all 0 after that edge.
- R2: With `delay_short` low when the power-on interval starts, `oe_drive` goes to 1 after exactly LONG_CYCLES + 1 rising edges that sample `supply_ok` high. The first of these edges leaves the off state.
- R3: With `delay_short` high when the interval starts, the same count is SHORT_CYCLES + 1.
- R4: `delay_short` is read only on entry to the power-on interval. Changing it during the interval does not change its length.
- R5: If the synchronized done level is 1 in the first cycle with `oe_drive` high, the block locks idle from the next cycle on: `idle_locked`=1, `oe_drive`=1, `stream_en`=0. It keeps these values whatever `status_n`, `conf_done` or `data_end` do, until `supply_ok` goes low.
- R6: If that done level is 0, `stream_en` goes to 1 in the next cycle and stays 1 until `data_end` or a restart. `stream_en` is never 1 while `oe_drive` is 0.
- R7: A `data_end` pulse while streaming drops `stream_en` on the next cycle, with `oe_drive` still 1. One cycle later the block keeps `oe_drive` high if synchronized done is 1. If done is 0, it drops `oe_drive` and begins a new power-on interval.
- R8: A low synchronized status while streaming, checking or running drops `oe_drive` and begins a new power-on interval, which is followed by a fresh release.
- R9: `supply_ok` low at any edge, the idle lock included, returns all outputs to 0. When the supply comes back, the full sequence starts again.
- R10: `status_n` and `conf_done` each pass through two flops before use. A change seen at edge k acts on the state at edge k+2, and the outputs show it after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply valid flag; low forces the off state |
| delay_short | input | 1 | 1 selects the short power-on interval, 0 the long one |
| status_n | input | 1 | Target status, low requests a new configuration |
| conf_done | input | 1 | Target done level |
| data_end | input | 1 | Single-cycle pulse when all data has been sent |
| oe_drive | output | 1 | Output-enable release, 1 means released (high) |
| stream_en | output | 1 | Enables data and clock streaming |
| idle_locked | output | 1 | Idle lock-up indicator |

## Verification
The bench aims at the idle trap, where done is already high at the release edge. A design that sampled done later or ignored it would start streaming into a target that never listens. It also times both delay settings exactly and flips the select pin during the interval; a design that read the pin continuously would release early or late. Other cases are a supply dip during streaming, a status-low restart, and a data end without done. A design that handled these wrong would keep streaming into a dead load, or would miss the two-cycle synchronizer delay and react one cycle early.

// File: rtl/cps_pkg.sv
// Shared types for the configuration power-on sequencer.
// Assumes nothing beyond a single clock domain for the state machine.
package cps_pkg;
    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_POR     = 3'd1,
        ST_RELEASE = 3'd2,
        ST_CONFIG  = 3'd3,
        ST_CHECK   = 3'd4,
        ST_RUN     = 3'd5,
        ST_IDLE    = 3'd6
    } seq_state_t;
endpackage

// File: rtl/cps_sync.sv
// Multi-stage synchronizer for asynchronous target status lines.
// Assumes the input may change at any time; the output lags by STAGES edges.
module cps_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe;

    // First stage captures the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= RST_VAL;
        else        pipe[0] <= din;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            // Each later stage copies its predecessor.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[g] <= RST_VAL;
                else        pipe[g] <= pipe[g-1];
            end
        end
    endgenerate

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/cps_timer.sv
// Power-on interval timer. Latches the delay choice on start and counts
// cycles while run is high. Assumes both limits are at least 1.
module cps_timer #(
    parameter int SHORT_CYCLES = 20,
    parameter int LONG_CYCLES  = 100,
    localparam int MAXC = (SHORT_CYCLES > LONG_CYCLES) ? SHORT_CYCLES : LONG_CYCLES,
    localparam int CW   = $clog2(MAXC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic sel_short,
    input  logic run,
    output logic expired
);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CYCLES - 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CYCLES - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last_q;

    assign expired = (cnt == last_q);

    // Load the chosen limit on start, otherwise advance while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            last_q <= LONG_LAST;
        end else if (start) begin
            cnt    <= '0;
            last_q <= sel_short ? SHORT_LAST : LONG_LAST;
        end else if (run && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cps_fsm.sv
// Sequencing state machine: off, power-on wait, release, stream, check,
// run and idle lock. Assumes status and done arrive already synchronized.
module cps_fsm
    import cps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       status_ok,
    input  logic       done_s,
    input  logic       data_end,
    input  logic       tmr_expired,
    output logic       tmr_start,
    output logic       tmr_run,
    output seq_state_t state
);
    seq_state_t nxt;

    // Next-state selection; supply loss overrides every other cause.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:     if (supply_ok) nxt = ST_POR;
            ST_POR:     if (tmr_expired) nxt = ST_RELEASE;
            ST_RELEASE: nxt = done_s ? ST_IDLE : ST_CONFIG;
            ST_CONFIG:  if (!status_ok) nxt = ST_POR;
                        else if (data_end) nxt = ST_CHECK;
            ST_CHECK:   nxt = (status_ok && done_s) ? ST_RUN : ST_POR;
            ST_RUN:     if (!status_ok) nxt = ST_POR;
            ST_IDLE:    nxt = ST_IDLE;
            default:    nxt = ST_OFF;
        endcase
        if (!supply_ok) nxt = ST_OFF;
    end

    assign tmr_start = (nxt == ST_POR) && (state != ST_POR);
    assign tmr_run   = (state == ST_POR);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end
endmodule

// File: rtl/cfg_power_sequencer.sv
// Top of the configuration power-on sequencer. Synchronizes target lines,
// times the power-on interval and decodes the control outputs from state.
// Assumes supply_ok is already synchronous to clk.
module cfg_power_sequencer
    import cps_pkg::*;
#(
    parameter int SHORT_CYCLES = 20,
    parameter int LONG_CYCLES  = 100,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic delay_short,
    input  logic status_n,
    input  logic conf_done,
    input  logic data_end,
    output logic oe_drive,
    output logic stream_en,
    output logic idle_locked
);
    logic       status_ok;
    logic       done_s;
    logic       tmr_start;
    logic       tmr_run;
    logic       tmr_expired;
    seq_state_t state;

    cps_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_status (
        .clk(clk), .rst_n(rst_n), .din(status_n), .dout(status_ok)
    );

    cps_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_done (
        .clk(clk), .rst_n(rst_n), .din(conf_done), .dout(done_s)
    );

    cps_timer #(.SHORT_CYCLES(SHORT_CYCLES), .LONG_CYCLES(LONG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .sel_short(delay_short),
        .run(tmr_run), .expired(tmr_expired)
    );

    cps_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .status_ok(status_ok),
        .done_s(done_s), .data_end(data_end), .tmr_expired(tmr_expired),
        .tmr_start(tmr_start), .tmr_run(tmr_run), .state(state)
    );

    // Output decode from the registered state.
    always_comb begin
        oe_drive    = (state != ST_OFF) && (state != ST_POR);
        stream_en   = (state == ST_CONFIG);
        idle_locked = (state == ST_IDLE);
    end
endmodule

// File: rtl/cps_checker.sv
// Port-level properties of the sequencer, bound onto every instance.
module cps_checker (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic oe_drive,
    input logic stream_en,
    input logic idle_locked
);
    // R9
    supply_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!oe_drive && !stream_en && !idle_locked));

    // R6
    stream_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stream_en |-> oe_drive);

    // R6
    release_before_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stream_en) |-> $past(oe_drive));

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_locked |-> (oe_drive && !stream_en));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_locked && supply_ok) |=> idle_locked);
endmodule

bind cfg_power_sequencer cps_checker u_chk (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .oe_drive(oe_drive),
    .stream_en(stream_en), .idle_locked(idle_locked)
);

// File: tb/sim_cfg_power_sequencer.sv
module sim_cfg_power_sequencer;
    localparam int SHORT = 12;
    localparam int LONG  = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0, supply_ok = 1'b0, delay_short = 1'b0;
    logic status_n = 1'b1, conf_done = 1'b0, data_end = 1'b0;
    logic oe_drive, stream_en, idle_locked;

    int checks = 0, fails = 0, cycles = 0;

    always #10 clk = ~clk;

    cfg_power_sequencer #(.SHORT_CYCLES(SHORT), .LONG_CYCLES(LONG)) u0 (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .delay_short(delay_short),
        .status_n(status_n), .conf_done(conf_done), .data_end(data_end),
        .oe_drive(oe_drive), .stream_en(stream_en), .idle_locked(idle_locked)
    );

    // Behavioural reference: phase 0 off, 1 wait, 2 release, 3 stream,
    // 4 check, 5 run, 6 idle lock.
    int m_phase = 0, m_left = 0;
    int st_q[$] = '{1, 1};
    int dn_q[$] = '{0, 0};

    always @(posedge clk) begin
        int st_seen, dn_seen, nxt;
        if (!rst_n) begin
            m_phase = 0;
            st_q = '{1, 1};
            dn_q = '{0, 0};
        end else begin
            st_seen = st_q[0];
            dn_seen = dn_q[0];
            void'(st_q.pop_front()); st_q.push_back(int'(status_n));
            void'(dn_q.pop_front()); dn_q.push_back(int'(conf_done));
            nxt = m_phase;
            if (m_phase == 0) nxt = 1;
            else if (m_phase == 1) begin
                if (m_left == 1) nxt = 2; else m_left--;
            end
            else if (m_phase == 2) nxt = (dn_seen != 0) ? 6 : 3;
            else if (m_phase == 3) begin
                if (st_seen == 0) nxt = 1; else if (data_end) nxt = 4;
            end
            else if (m_phase == 4) nxt = (st_seen != 0 && dn_seen != 0) ? 5 : 1;
            else if (m_phase == 5) begin
                if (st_seen == 0) nxt = 1;
            end
            if (!supply_ok) nxt = 0;
            if (nxt == 1 && m_phase != 1) m_left = delay_short ? SHORT : LONG;
            m_phase = nxt;
        end
    end

    function automatic string tag_of(int p);
        case (p)
            0: return "R9";
            1: return "R2";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            5: return "R8";
            default: return "R5";
        endcase
    endfunction

    // Compare the outputs with the reference on every cycle.
    always @(negedge clk) begin
        int exp_v, act_v;
        cycles++;
        exp_v = ((m_phase >= 2) ? 4 : 0) + ((m_phase == 3) ? 2 : 0) + ((m_phase == 6) ? 1 : 0);
        act_v = {29'd0, oe_drive, stream_en, idle_locked};
        checks++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s cycle %0d outputs actual %0d expected %0d",
                     tag_of(m_phase), cycles, act_v, exp_v);
        end
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual %0d expected below 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Count edges until oe rises; optionally flip the select mid-interval.
    task automatic wait_release(output int n, input bit flip);
        n = 0;
        while (!oe_drive && n < 1000) begin
            @(negedge clk);
            n++;
            if (flip && n == 5) delay_short = ~delay_short;
        end
    endtask

    initial begin
        int n;
        cyc(3);
        // R1: held in reset
        chk(!oe_drive && !stream_en && !idle_locked, "R1", oe_drive, 0);
        rst_n = 1'b1;
        cyc(2);
        chk(!oe_drive, "R1", oe_drive, 0);

        // R2, R4: long delay, select flipped during interval
        supply_ok = 1'b1; delay_short = 1'b0;
        wait_release(n, 1'b1);
        chk(n == LONG + 1, "R2", n, LONG + 1);
        delay_short = 1'b0;
        chk(n == LONG + 1, "R4", n, LONG + 1);
        cyc(1);
        chk(stream_en == 1'b1, "R6", stream_en, 1);
        cyc(10);
        chk(stream_en == 1'b1, "R6", stream_en, 1);

        // R7: data end with done high keeps oe up
        conf_done = 1'b1; cyc(3);
        data_end = 1'b1; cyc(1); data_end = 1'b0;
        chk(!stream_en && oe_drive, "R7", stream_en, 0);
        cyc(1);
        chk(oe_drive == 1'b1, "R7", oe_drive, 1);
        cyc(5);

        // R8, R10: status low restart seen after the synchronizer
        status_n = 1'b0;
        cyc(2);
        chk(oe_drive == 1'b1, "R10", oe_drive, 1);
        cyc(1);
        chk(oe_drive == 1'b0, "R8", oe_drive, 0);
        status_n = 1'b1; conf_done = 1'b0;
        wait_release(n, 1'b0);
        chk(n == LONG, "R8", n, LONG);
        cyc(4);

        // R9: supply dip while streaming
        supply_ok = 1'b0; cyc(1);
        chk(!oe_drive && !stream_en, "R9", oe_drive, 0);
        supply_ok = 1'b1;
        wait_release(n, 1'b0);
        chk(n == LONG + 1, "R9", n, LONG + 1);
        cyc(3);

        // R7: data end with done still low forces a restart
        data_end = 1'b1; cyc(1); data_end = 1'b0;
        cyc(1);
        chk(oe_drive == 1'b0, "R7", oe_drive, 0);
        cyc(5);

        // R3, R5: short delay with done already high locks idle
        supply_ok = 1'b0; cyc(2);
        delay_short = 1'b1; conf_done = 1'b1; supply_ok = 1'b1;
        wait_release(n, 1'b0);
        chk(n == SHORT + 1, "R3", n, SHORT + 1);
        cyc(1);
        chk(idle_locked && !stream_en, "R5", idle_locked, 1);
        status_n = 1'b0; cyc(6); status_n = 1'b1;
        data_end = 1'b1; cyc(1); data_end = 1'b0;
        conf_done = 1'b0; cyc(20);
        chk(idle_locked && oe_drive && !stream_en, "R5", idle_locked, 1);

        // R9: only a supply cycle clears the lock
        supply_ok = 1'b0; cyc(1);
        chk(!idle_locked && !oe_drive, "R9", idle_locked, 0);
        supply_ok = 1'b1;
        wait_release(n, 1'b0);
        chk(n == SHORT + 1, "R3", n, SHORT + 1);
        cyc(1);
        chk(stream_en == 1'b1, "R6", stream_en, 1);
        cyc(5);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule